// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit forms the byte address of an instruction operand for a 32-bit, byte-addressed processor. Each cycle it can take one request: a 3-bit addressing mode, the values read from two register-file ports, the program counter already advanced past the current instruction, a signed offset field and an operand size code. One clock later it returns the effective address and a strobe that the operand is fetched through memory.

For the two auto-modify modes it also returns the new value of the pointer register on a separate write-back port. The step is the operand size in bytes. Autoincrement uses the old pointer as the address and then bumps it. Autodecrement lowers the pointer first and uses the lowered value.

Unused mode codes, and auto-modify requests with an unusable size code, raise an illegal flag and produce no write-back. All arithmetic wraps modulo 2^AW.

Top module: `ea_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, valid_o, mem_op_o, illegal_o and wb_en_o are 0 and ea_o and wb_data_o are 0.
- R2: Mode 0 (register indirect) gives ea_o = reg_a_i, mem_op_o = 1, wb_en_o = 0.
- R3: Mode 1 (indexed) gives ea_o = reg_a_i + sign-extended offset_i, with wb_en_o = 0 so the index register is left alone.
- R4: Mode 2 (base-indexed) gives ea_o = reg_a_i + reg_b_i, wb_en_o = 0.
- R5: Mode 3 (base-indexed with offset) gives ea_o = reg_a_i + reg_b_i + sign-extended offset_i, wb_en_o = 0.
- R6: Mode 4 (PC-relative) gives ea_o = pc_next_i + sign-extended offset_i. For example, offset -16 with pc_next_i 1016 gives 1000.
- R7: Mode 5 (autoincrement) gives ea_o = reg_a_i, wb_en_o = 1 and wb_data_o = reg_a_i + step.
- R8: Mode 6 (autodecrement) gives ea_o = wb_data_o = reg_a_i - step, wb_en_o = 1.
- R9: The step depends on size_i: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. size_i = 3 in mode 5 or 6 sets illegal_o = 1 with wb_en_o = 0.
- R10: Mode 7 is reserved. It gives illegal_o = 1, mem_op_o = 0, wb_en_o = 0 and ea_o = 0.
- R11: All sums and differences wrap modulo 2^AW. offset_i is treated as a two's-complement value of OFF_W bits.
- R12: Results appear one clock after a cycle with valid_i = 1, and valid_o is 1 in that cycle. After a cycle with valid_i = 0, valid_o, mem_op_o, illegal_o and wb_en_o are 0, and ea_o and wb_data_o keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| mode_i | input | 3 | Addressing mode code |
| size_i | input | 2 | Operand size code (0 byte, 1 half, 2 word) |
| reg_a_i | input | AW | Pointer, index or base register value |
| reg_b_i | input | AW | Second register value for base-indexed modes |
| pc_next_i | input | AW | PC already advanced past the instruction |
| offset_i | input | OFF_W | Signed constant offset |
| valid_o | output | 1 | Result valid |
| ea_o | output | AW | Effective address |
| mem_op_o | output | 1 | Operand is fetched through memory |
| illegal_o | output | 1 | Request was illegal |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_data_o | output | AW | Updated pointer value |

## Verification
The bench builds the unit with AW = 32 and OFF_W = 12. The narrow offset field puts the sign boundary within reach of directed values: 0x800 decodes to -2048 and 0xFFC decodes to -4, so sign extension is exercised in the indexed, base-indexed-with-offset and PC-relative modes. The full 32-bit width lets pointers near 0 and near 0xFFFFFFFF check wrap-around in both directions of auto-modify.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;
  typedef enum logic [2:0] {
    EA_IND  = 3'd0,
    EA_IDX  = 3'd1,
    EA_BIX  = 3'd2,
    EA_BIXO = 3'd3,
    EA_REL  = 3'd4,
    EA_AINC = 3'd5,
    EA_ADEC = 3'd6,
    EA_RSV  = 3'd7
  } ea_mode_e;

  localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/ea_sext.sv
`timescale 1ns/1ps
module ea_sext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  generate
    if (IN_W >= OUT_W) begin : g_trunc
      assign val_o = val_i[OUT_W-1:0];
    end else begin : g_ext
      localparam int unsigned PAD_W = OUT_W - IN_W;
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/ea_step.sv
`timescale 1ns/1ps
module ea_step
  import ea_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [AW-1:0]     step_o,
  output logic [AW-1:0]     neg_step_o,
  output logic              size_ok_o
);
  always_comb begin
    step_o    = '0;
    size_ok_o = 1'b1;
    unique case (size_i)
      2'd0:    step_o[0] = 1'b1;
      2'd1:    step_o[1] = 1'b1;
      2'd2:    step_o[2] = 1'b1;
      default: size_ok_o = 1'b0;
    endcase
  end

  assign neg_step_o = ~step_o + {{(AW-1){1'b0}}, 1'b1};

  // R9
  step_onehot_chk: assert property (@(size_i) size_ok_o |-> $onehot0(step_o) && step_o != '0)
    else $error("step not a single power of two");
endmodule

// File: rtl/ea_add3.sv
`timescale 1ns/1ps
module ea_add3 #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic [AW-1:0] c_i,
  output logic [AW-1:0] sum_o
);
  assign sum_o = a_i + b_i + c_i;
endmodule

// File: rtl/ea_unit.sv
`timescale 1ns/1ps
module ea_unit
  import ea_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [AW-1:0]     reg_a_i,
  input  logic [AW-1:0]     reg_b_i,
  input  logic [AW-1:0]     pc_next_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              valid_o,
  output logic [AW-1:0]     ea_o,
  output logic              mem_op_o,
  output logic              illegal_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_data_o
);
  ea_mode_e      mode;
  logic [AW-1:0] off_ext, step, neg_step, op_a, op_b, op_c, ea_sum, upd_sum, delta;
  logic          size_ok, is_auto, bad;

  assign mode = ea_mode_e'(mode_i);

  ea_sext #(.IN_W(OFF_W), .OUT_W(AW)) u_sext (
    .val_i (offset_i),
    .val_o (off_ext)
  );

  ea_step #(.AW(AW)) u_step (
    .size_i     (size_i),
    .step_o     (step),
    .neg_step_o (neg_step),
    .size_ok_o  (size_ok)
  );

  assign is_auto = (mode == EA_AINC) || (mode == EA_ADEC);
  assign bad     = (mode == EA_RSV) || (is_auto && !size_ok);
  assign delta   = (mode == EA_ADEC) ? neg_step : step;

  always_comb begin
    op_a = '0;
    op_b = '0;
    op_c = '0;
    unique case (mode)
      EA_IND:  op_a = reg_a_i;
      EA_IDX:  begin op_a = reg_a_i;   op_b = off_ext; end
      EA_BIX:  begin op_a = reg_a_i;   op_b = reg_b_i; end
      EA_BIXO: begin op_a = reg_a_i;   op_b = reg_b_i; op_c = off_ext; end
      EA_REL:  begin op_a = pc_next_i; op_b = off_ext; end
      EA_AINC: op_a = reg_a_i;
      EA_ADEC: begin op_a = reg_a_i;   op_b = neg_step; end
      default: ;
    endcase
  end

  ea_add3 #(.AW(AW)) u_ea_add (
    .a_i   (op_a),
    .b_i   (op_b),
    .c_i   (op_c),
    .sum_o (ea_sum)
  );

  // pointer update path, separate from the address path
  ea_add3 #(.AW(AW)) u_upd_add (
    .a_i   (reg_a_i),
    .b_i   (delta),
    .c_i   ('0),
    .sum_o (upd_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      ea_o      <= '0;
      mem_op_o  <= 1'b0;
      illegal_o <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_data_o <= '0;
    end else begin
      valid_o   <= valid_i;
      mem_op_o  <= valid_i && !bad;
      illegal_o <= valid_i && bad;
      wb_en_o   <= valid_i && is_auto && !bad;
      if (valid_i) begin
        ea_o      <= bad ? '0 : ea_sum;
        wb_data_o <= (is_auto && !bad) ? upd_sum : wb_data_o;
      end
    end
  end

  // R12
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing one cycle after request");

  // R12
  ea_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ea_o) && !wb_en_o) else $error("result changed without request");

  // R10
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o && !mem_op_o) else $error("illegal request had side effects");

  // R7
  wb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o && ((wb_data_o == ea_o) || ((wb_data_o - ea_o) == 1)
                || ((wb_data_o - ea_o) == 2) || ((wb_data_o - ea_o) == 4)))
    else $error("write-back not a legal step from address");
endmodule

// File: tb/ea_unit_tb.sv
`timescale 1ns/1ps
module ea_unit_tb_top;
  localparam int unsigned AW    = 32;
  localparam int unsigned OFF_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [2:0]        mode = '0;
  logic [1:0]        size = '0;
  logic [AW-1:0]     ra = '0, rb = '0, pc = '0;
  logic [OFF_W-1:0]  off = '0;
  logic              valid_o, mem_op_o, illegal_o, wb_en_o;
  logic [AW-1:0]     ea_o, wb_data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ea_unit #(.AW(AW), .OFF_W(OFF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .size_i(size),
    .reg_a_i(ra), .reg_b_i(rb), .pc_next_i(pc), .offset_i(off),
    .valid_o(valid_o), .ea_o(ea_o), .mem_op_o(mem_op_o), .illegal_o(illegal_o),
    .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [AW-1:0] sx(input logic [OFF_W-1:0] v);
    return {{(AW-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request, sampled at the negedge after the capturing posedge
  task automatic issue(input string tag, input logic [2:0] m, input logic [1:0] s,
                       input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic [AW-1:0] p, input logic [OFF_W-1:0] o,
                       input logic [AW-1:0] exp_ea, input logic exp_mem,
                       input logic exp_ill, input logic exp_wb,
                       input logic [AW-1:0] exp_wbd);
    @(negedge clk);
    valid = 1'b1; mode = m; size = s; ra = a; rb = b; pc = p; off = o;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " valid"}, {31'b0, valid_o}, 32'd1);
    chk({tag, " ea"}, ea_o, exp_ea);
    chk({tag, " mem"}, {31'b0, mem_op_o}, {31'b0, exp_mem});
    chk({tag, " ill"}, {31'b0, illegal_o}, {31'b0, exp_ill});
    chk({tag, " wb_en"}, {31'b0, wb_en_o}, {31'b0, exp_wb});
    if (exp_wb) chk({tag, " wb_data"}, wb_data_o, exp_wbd);
  endtask

  task automatic t_reset();
    chk("R1 valid", {31'b0, valid_o}, 32'd0);
    chk("R1 ea", ea_o, 32'd0);
    chk("R1 flags", {28'b0, mem_op_o, illegal_o, wb_en_o, 1'b0}, 32'd0);
    chk("R1 wb_data", wb_data_o, 32'd0);
  endtask

  task automatic t_indirect();
    issue("R2 ind", 3'd0, 2'd2, 32'h1000_0040, 32'h5, 32'h0, 12'h7FF,
          32'h1000_0040, 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_indexed();
    issue("R3 idx pos", 3'd1, 2'd2, 32'd1000, 32'd0, 32'd0, 12'd20,
          32'd1020, 1'b1, 1'b0, 1'b0, 32'h0);
    issue("R3 idx neg", 3'd1, 2'd2, 32'h100, 32'd0, 32'd0, 12'hFFC,
          32'h100 + sx(12'hFFC), 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_base();
    issue("R4 bix", 3'd2, 2'd0, 32'h200, 32'h30, 32'd0, 12'h123,
          32'h230, 1'b1, 1'b0, 1'b0, 32'h0);
    issue("R5 bixo", 3'd3, 2'd0, 32'd1000, 32'd20, 32'd0, 12'h800,
          32'd1020 - 32'd2048, 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_relative();
    issue("R6 rel", 3'd4, 2'd2, 32'hDEAD, 32'hBEEF, 32'd1016, 12'hFF0,
          32'd1000, 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_autoinc();
    issue("R7 R9 ainc b", 3'd5, 2'd0, 32'h40, 32'd0, 32'd0, 12'd0, 32'h40, 1'b1, 1'b0, 1'b1, 32'h41);
    issue("R7 R9 ainc h", 3'd5, 2'd1, 32'h40, 32'd0, 32'd0, 12'd0, 32'h40, 1'b1, 1'b0, 1'b1, 32'h42);
    issue("R7 R9 ainc w", 3'd5, 2'd2, 32'h40, 32'd0, 32'd0, 12'd0, 32'h40, 1'b1, 1'b0, 1'b1, 32'h44);
  endtask

  task automatic t_autodec();
    issue("R8 adec w", 3'd6, 2'd2, 32'h40, 32'd0, 32'd0, 12'd0, 32'h3C, 1'b1, 1'b0, 1'b1, 32'h3C);
    issue("R8 adec h", 3'd6, 2'd1, 32'h40, 32'd0, 32'd0, 12'd0, 32'h3E, 1'b1, 1'b0, 1'b1, 32'h3E);
  endtask

  task automatic t_bad_size();
    issue("R9 ainc size3", 3'd5, 2'd3, 32'h40, 32'd0, 32'd0, 12'd0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    issue("R9 adec size3", 3'd6, 2'd3, 32'h40, 32'd0, 32'd0, 12'd0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_reserved();
    issue("R10 rsv", 3'd7, 2'd2, 32'h40, 32'h8, 32'h10, 12'd4, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_wrap();
    issue("R11 ainc wrap", 3'd5, 2'd2, 32'hFFFF_FFFE, 32'd0, 32'd0, 12'd0,
          32'hFFFF_FFFE, 1'b1, 1'b0, 1'b1, 32'h2);
    issue("R11 adec wrap", 3'd6, 2'd0, 32'h0, 32'd0, 32'd0, 12'd0,
          32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    issue("R11 bixo wrap", 3'd3, 2'd0, 32'hFFFF_FFF0, 32'h20, 32'd0, 12'h7FF,
          32'h10 + 32'h7FF, 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_hold();
    issue("R12 seed", 3'd5, 2'd2, 32'h500, 32'd0, 32'd0, 12'd0, 32'h500, 1'b1, 1'b0, 1'b1, 32'h504);
    @(negedge clk);
    valid = 1'b0; mode = 3'd2; ra = 32'h9999; rb = 32'h1;
    @(negedge clk);
    chk("R12 idle valid", {31'b0, valid_o}, 32'd0);
    chk("R12 idle ea", ea_o, 32'h500);
    chk("R12 idle wb_data", wb_data_o, 32'h504);
    chk("R12 idle strobes", {29'b0, mem_op_o, illegal_o, wb_en_o}, 32'd0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indirect();
    t_indexed();
    t_base();
    t_relative();
    t_autoinc();
    t_autodec();
    t_bad_size();
    t_reserved();
    t_wrap();
    t_hold();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule